// File: doc/BRIEF.md
# Dual-Port Inter-Processor Message Box

Two processors exchange 32-bit words through this block. Each processor owns a simple register port, one for the application side and one for the coprocessor side. There are eight channels, and each one is a one-way queue that holds up to four words. Shared direction bits choose which side may load a channel and which side may drain it. Each side gets its own interrupt enable and status registers. It can also read the peer's enable and status registers, so a sender can poll for the moment its message has been drained and acknowledged. Each side has one level-sensitive interrupt output.

A data write from the transmitting side queues a word. A data read from the receiving side returns the oldest word and removes it. Each channel is tracked by a three-state machine:

- States: `CH_EMPTY`, `CH_PART` (one to three words held) and `CH_FULL`.
- Transitions: fill (`CH_EMPTY`→`CH_PART` on an accepted push), top (`CH_PART`→`CH_FULL` when the fourth word arrives), drain (`CH_PART`→`CH_EMPTY` when the last word is popped) and relieve (`CH_FULL`→`CH_PART` on a pop).

The receive interrupt of a channel is sticky. A write-one clear only takes effect once that channel's queue is empty.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every queue is empty, both direction words read 0, both enable registers read 0, no receive status bit is set, and both interrupt outputs are low.
- R2: Direction word k (byte address 4k) covers channels 4k..4k+3. For the channel with index c = 4k+j, bit 8j set makes the application side the receiver, and bit 8j+4 set makes the application side the transmitter; when a bit is clear, the coprocessor side holds that role. All other bits read 0. If both ports write the same direction word in one cycle, the coprocessor's data is stored.
- R3: A write to 0x180+4c from the transmitting side appends the word to channel c if fewer than 4 words are held. 0x140+4c reads the word count in bits [2:0], and 0x100+4c reads 1 in bit 0 when the queue holds 4 words.
- R4: A push to a full queue is dropped, and so is a data write from the side that is not the transmitter. In both cases the queue contents and count are left unchanged.
- R5: A read of 0x180+4c by the receiving side returns the oldest word and removes it. On an empty queue, or when read by the non-receiving side, the read returns 0 and the count is unchanged.
- R6: Status bit 2c of a side (local status at 0x070) sets when a push to channel c is accepted and that side is the receiver of channel c.
- R7: Writing 1 to status bit 2c clears it only when channel c is empty. While the queue holds data, the bit stays set.
- R8: Status bit 2c+1 of a side reads 1 exactly when that side is the transmitter of channel c and the queue is not full. Writes to it have no effect.
- R9: Each side's interrupt output is high while any bit is set in both its enable register (0x060) and its status register.
- R10: A side reads the peer's enable register at 0x040 and the peer's status register at 0x050.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| app_sel | input | 1 | Application-side access strobe |
| app_wr | input | 1 | Application-side write (1) or read (0) |
| app_addr | input | 9 | Application-side byte address |
| app_wdata | input | 32 | Application-side write data |
| app_rdata | output | 32 | Application-side read data, valid in the access cycle |
| app_irq | output | 1 | Application-side level interrupt |
| cop_sel | input | 1 | Coprocessor-side access strobe |
| cop_wr | input | 1 | Coprocessor-side write (1) or read (0) |
| cop_addr | input | 9 | Coprocessor-side byte address |
| cop_wdata | input | 32 | Coprocessor-side write data |
| cop_rdata | output | 32 | Coprocessor-side read data, valid in the access cycle |
| cop_irq | output | 1 | Coprocessor-side level interrupt |

## Verification
The checker watches several properties on every cycle:
- queue counts stay within 0..4 and move by at most one per cycle;
- the full flag agrees with the count;
- a set receive bit survives any cycle in which its queue is non-empty;
- no transmit bit is raised on a full queue;
- an interrupt never rises without a status bit;
- a data read of an empty queue returns 0.

Only the directed scenarios can show the rest:
- the order in which words come out, and the drop of a fifth word;
- the rejection of writes from the wrong side;
- the collision rule on the direction words;
- the mirrored peer view that a sender polls for acknowledgement.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int ADDR_W = 9;

    // Register map offsets (byte addresses)
    localparam int OFS_REM_EN = 'h040;
    localparam int OFS_REM_ST = 'h050;
    localparam int OFS_LOC_EN = 'h060;
    localparam int OFS_LOC_ST = 'h070;
    localparam int OFS_FULL   = 'h100;
    localparam int OFS_CNT    = 'h140;
    localparam int OFS_DATA   = 'h180;

    typedef enum logic [1:0] {
        CH_EMPTY = 2'd0,
        CH_PART  = 2'd1,
        CH_FULL  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          push_ok
);

    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] wp_q, rp_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          pop_ok;

    // Next-state logic: fill, top, drain, relieve
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_EMPTY: if (push_ok) st_d = CH_PART;
            CH_PART: begin
                if (push_ok && !pop_ok && cnt_q == CW'(DEPTH - 1))
                    st_d = CH_FULL;
                else if (pop_ok && !push_ok && cnt_q == CW'(1))
                    st_d = CH_EMPTY;
            end
            CH_FULL:  if (pop_ok) st_d = CH_PART;
            default:  st_d = CH_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_EMPTY;
        else        st_q <= st_d;
    end

    // Outputs derived from the state
    always_comb begin
        full    = (st_q == CH_FULL);
        empty   = (st_q == CH_EMPTY);
        push_ok = push && (st_q != CH_FULL);
        pop_ok  = pop && (st_q != CH_EMPTY);
        head    = mem_q[rp_q];
        count   = cnt_q;
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wp_q  <= '0;
            rp_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
            if (push_ok) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            if (pop_ok)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
        end
    end

    // Storage, no reset needed: reads are gated by the count
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wp_q] <= wdata;
    end

endmodule

// File: rtl/ipc_mbox_port.sv
module ipc_mbox_port
    import ipc_mbox_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DEPTH  = 4,
    parameter int DW     = 32,
    parameter bit IS_APP = 1'b1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = 2 * NCH,
    localparam int NCW   = (NCH + 3) / 4
) (
    input  logic                     sel,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NCH-1:0]           dir_rx,
    input  logic [NCH-1:0]           dir_tx,
    input  logic [NCH-1:0][CW-1:0]   cnt,
    input  logic [NCH-1:0]           full,
    input  logic [NCH-1:0][DW-1:0]   head,
    input  logic [IW-1:0]            own_en,
    input  logic [IW-1:0]            own_st,
    input  logic [IW-1:0]            peer_en,
    input  logic [IW-1:0]            peer_st,
    output logic [DW-1:0]            rdata,
    output logic [NCH-1:0]           push,
    output logic [NCH-1:0]           pop,
    output logic [NCW-1:0]           ctrl_wr,
    output logic                     en_wr,
    output logic                     st_wr
);

    logic [NCH-1:0] me_rx, me_tx;

    // The direction bits name the application side; the other port inverts them
    generate
        if (IS_APP) begin : g_app_view
            assign me_rx = dir_rx;
            assign me_tx = dir_tx;
        end else begin : g_cop_view
            assign me_rx = ~dir_rx;
            assign me_tx = ~dir_tx;
        end
    endgenerate

    logic rd, wt;
    assign rd = sel && !wr;
    assign wt = sel && wr;

    always_comb begin
        rdata   = '0;
        push    = '0;
        pop     = '0;
        ctrl_wr = '0;
        en_wr   = 1'b0;
        st_wr   = 1'b0;

        for (int w = 0; w < NCW; w++) begin
            if (addr == ADDR_W'(4 * w)) begin
                ctrl_wr[w] = wt;
                if (rd) begin
                    for (int k = 0; k < 4; k++) begin
                        if (4 * w + k < NCH) begin
                            rdata[8 * k]     = dir_rx[4 * w + k];
                            rdata[8 * k + 4] = dir_tx[4 * w + k];
                        end
                    end
                end
            end
        end

        if (addr == ADDR_W'(OFS_REM_EN) && rd) rdata = DW'(peer_en);
        if (addr == ADDR_W'(OFS_REM_ST) && rd) rdata = DW'(peer_st);
        if (addr == ADDR_W'(OFS_LOC_EN)) begin
            en_wr = wt;
            if (rd) rdata = DW'(own_en);
        end
        if (addr == ADDR_W'(OFS_LOC_ST)) begin
            st_wr = wt;
            if (rd) rdata = DW'(own_st);
        end

        for (int n = 0; n < NCH; n++) begin
            if (addr == ADDR_W'(OFS_FULL + 4 * n) && rd) rdata = DW'(full[n]);
            if (addr == ADDR_W'(OFS_CNT + 4 * n) && rd)  rdata = DW'(cnt[n]);
            if (addr == ADDR_W'(OFS_DATA + 4 * n)) begin
                push[n] = wt && me_tx[n];
                pop[n]  = rd && me_rx[n];
                if (rd && me_rx[n] && cnt[n] != '0) rdata = head[n];
            end
        end
    end

endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
    parameter int NCH = 8,
    localparam int IW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_wr,
    input  logic [IW-1:0]  en_wdata,
    input  logic [NCH-1:0] clr_rx,
    input  logic [NCH-1:0] rx_set,
    input  logic [NCH-1:0] empty,
    input  logic [NCH-1:0] me_tx,
    input  logic [NCH-1:0] full,
    output logic [IW-1:0]  en,
    output logic [IW-1:0]  st,
    output logic           irq
);

    logic [IW-1:0]  en_q;
    logic [NCH-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            rx_q <= '0;
        end else begin
            if (en_wr) en_q <= en_wdata;
            for (int n = 0; n < NCH; n++) begin
                // A new arrival wins; a clear lands only on an empty queue
                if (rx_set[n])                 rx_q[n] <= 1'b1;
                else if (clr_rx[n] && empty[n]) rx_q[n] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            st[2 * n]     = rx_q[n];
            st[2 * n + 1] = me_tx[n] && !full[n];
        end
        en  = en_q;
        irq = |(en_q & st);
    end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_sel,
    input  logic              app_wr,
    input  logic [ADDR_W-1:0] app_addr,
    input  logic [DW-1:0]     app_wdata,
    output logic [DW-1:0]     app_rdata,
    output logic              app_irq,
    input  logic              cop_sel,
    input  logic              cop_wr,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic [DW-1:0]     cop_wdata,
    output logic [DW-1:0]     cop_rdata,
    output logic              cop_irq
);

    localparam int CW  = $clog2(DEPTH + 1);
    localparam int IW  = 2 * NCH;
    localparam int NCW = (NCH + 3) / 4;

    logic [NCH-1:0]         dir_rx_q, dir_tx_q;   // 1 = application side
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0][DW-1:0] ch_head;
    logic [NCH-1:0]         ch_full, ch_empty, ch_push_ok;
    logic [NCH-1:0]         app_push, app_pop, cop_push, cop_pop;
    logic [NCH-1:0]         app_clr, cop_clr;
    logic [NCW-1:0]         app_ctrl_wr, cop_ctrl_wr;
    logic                   app_en_wr, cop_en_wr, app_st_wr, cop_st_wr;
    logic [IW-1:0]          app_en, app_st, cop_en, cop_st;

    // Direction words: coprocessor wins a same-word collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rx_q <= '0;
            dir_tx_q <= '0;
        end else begin
            for (int w = 0; w < NCW; w++) begin
                for (int k = 0; k < 4; k++) begin
                    if (4 * w + k < NCH) begin
                        if (cop_ctrl_wr[w]) begin
                            dir_rx_q[4 * w + k] <= cop_wdata[8 * k];
                            dir_tx_q[4 * w + k] <= cop_wdata[8 * k + 4];
                        end else if (app_ctrl_wr[w]) begin
                            dir_rx_q[4 * w + k] <= app_wdata[8 * k];
                            dir_tx_q[4 * w + k] <= app_wdata[8 * k + 4];
                        end
                    end
                end
            end
        end
    end

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            ipc_mbox_chan #(.DEPTH(DEPTH), .DW(DW)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .push    (app_push[n] | cop_push[n]),
                .pop     (app_pop[n] | cop_pop[n]),
                .wdata   (dir_tx_q[n] ? app_wdata : cop_wdata),
                .head    (ch_head[n]),
                .count   (ch_cnt[n]),
                .full    (ch_full[n]),
                .empty   (ch_empty[n]),
                .push_ok (ch_push_ok[n])
            );
            assign app_clr[n] = app_st_wr && app_wdata[2 * n];
            assign cop_clr[n] = cop_st_wr && cop_wdata[2 * n];
        end
    endgenerate

    ipc_mbox_port #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW), .IS_APP(1'b1)) u_app_port (
        .sel (app_sel), .wr (app_wr), .addr (app_addr),
        .dir_rx (dir_rx_q), .dir_tx (dir_tx_q),
        .cnt (ch_cnt), .full (ch_full), .head (ch_head),
        .own_en (app_en), .own_st (app_st), .peer_en (cop_en), .peer_st (cop_st),
        .rdata (app_rdata), .push (app_push), .pop (app_pop),
        .ctrl_wr (app_ctrl_wr), .en_wr (app_en_wr), .st_wr (app_st_wr)
    );

    ipc_mbox_port #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW), .IS_APP(1'b0)) u_cop_port (
        .sel (cop_sel), .wr (cop_wr), .addr (cop_addr),
        .dir_rx (dir_rx_q), .dir_tx (dir_tx_q),
        .cnt (ch_cnt), .full (ch_full), .head (ch_head),
        .own_en (cop_en), .own_st (cop_st), .peer_en (app_en), .peer_st (app_st),
        .rdata (cop_rdata), .push (cop_push), .pop (cop_pop),
        .ctrl_wr (cop_ctrl_wr), .en_wr (cop_en_wr), .st_wr (cop_st_wr)
    );

    ipc_mbox_irq #(.NCH(NCH)) u_app_irq (
        .clk (clk), .rst_n (rst_n),
        .en_wr (app_en_wr), .en_wdata (app_wdata[IW-1:0]), .clr_rx (app_clr),
        .rx_set (ch_push_ok & dir_rx_q), .empty (ch_empty),
        .me_tx (dir_tx_q), .full (ch_full),
        .en (app_en), .st (app_st), .irq (app_irq)
    );

    ipc_mbox_irq #(.NCH(NCH)) u_cop_irq (
        .clk (clk), .rst_n (rst_n),
        .en_wr (cop_en_wr), .en_wdata (cop_wdata[IW-1:0]), .clr_rx (cop_clr),
        .rx_set (ch_push_ok & ~dir_rx_q), .empty (ch_empty),
        .me_tx (~dir_tx_q), .full (ch_full),
        .en (cop_en), .st (cop_st), .irq (cop_irq)
    );

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = 2 * NCH
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0]         full,
    input logic [IW-1:0]          app_st,
    input logic [IW-1:0]          cop_st,
    input logic                   app_irq,
    input logic                   cop_irq,
    input logic                   app_sel,
    input logic                   app_wr,
    input logic [ADDR_W-1:0]      app_addr,
    input logic [DW-1:0]          app_rdata
);

    // R9: an interrupt needs a status source
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        app_irq |-> app_st != '0);
    p_irq_src_cop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> cop_st != '0);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chk
            // R3: occupancy bounded and full flag tracks it
            p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                cnt[n] <= CW'(DEPTH));
            p_full_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
                full[n] == (cnt[n] == CW'(DEPTH)));
            // R4: count moves by at most one word per cycle
            p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (cnt[n] == $past(cnt[n])) ||
                         (cnt[n] == $past(cnt[n]) + CW'(1)) ||
                         (cnt[n] + CW'(1) == $past(cnt[n])));
            // R7: receive status sticks while the queue holds data
            p_rx_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (app_st[2 * n] && cnt[n] != '0) |=> app_st[2 * n]);
            p_rx_sticky_cop_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (cop_st[2 * n] && cnt[n] != '0) |=> cop_st[2 * n]);
            // R8: no transmit-ready on a full queue
            p_tx_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
                full[n] |-> !app_st[2 * n + 1] && !cop_st[2 * n + 1]);
            // R5: empty data read returns zero
            p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (app_sel && !app_wr && app_addr == ADDR_W'(OFS_DATA + 4 * n) &&
                 cnt[n] == '0) |-> app_rdata == '0);
        end
    endgenerate

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH), .DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (ch_cnt),
    .full      (ch_full),
    .app_st    (app_st),
    .cop_st    (cop_st),
    .app_irq   (app_irq),
    .cop_irq   (cop_irq),
    .app_sel   (app_sel),
    .app_wr    (app_wr),
    .app_addr  (app_addr),
    .app_rdata (app_rdata)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        app_sel = 0, app_wr = 0, cop_sel = 0, cop_wr = 0;
    logic [8:0]  app_addr = '0, cop_addr = '0;
    logic [31:0] app_wdata = '0, cop_wdata = '0;
    logic [31:0] app_rdata, cop_rdata;
    logic        app_irq, cop_irq;
    int          n_chk = 0, n_err = 0;
    logic [31:0] v;

    always #10 clk = ~clk;   // 50 MHz

    ipc_mailbox u_dut (
        .clk (clk), .rst_n (rst_n),
        .app_sel (app_sel), .app_wr (app_wr), .app_addr (app_addr),
        .app_wdata (app_wdata), .app_rdata (app_rdata), .app_irq (app_irq),
        .cop_sel (cop_sel), .cop_wr (cop_wr), .cop_addr (cop_addr),
        .cop_wdata (cop_wdata), .cop_rdata (cop_rdata), .cop_irq (cop_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // side: 0 = application, 1 = coprocessor
    task automatic bus_wr(input bit side, input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        if (!side) begin app_sel = 1; app_wr = 1; app_addr = a; app_wdata = d; end
        else       begin cop_sel = 1; cop_wr = 1; cop_addr = a; cop_wdata = d; end
        @(posedge clk); #1;
        app_sel = 0; app_wr = 0; cop_sel = 0; cop_wr = 0;
    endtask

    task automatic bus_rd(input bit side, input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        if (!side) begin app_sel = 1; app_wr = 0; app_addr = a; end
        else       begin cop_sel = 1; cop_wr = 0; cop_addr = a; end
        #2;
        d = side ? cop_rdata : app_rdata;
        @(posedge clk); #1;
        app_sel = 0; cop_sel = 0;
    endtask

    task automatic t_reset();
        bus_rd(0, 9'h000, v); check("R1 dir word", v, 0);
        bus_rd(0, 9'h060, v); check("R1 app enable", v, 0);
        bus_rd(0, 9'h070, v); check("R1 app status", v, 0);
        bus_rd(1, 9'h070, v); check("R1/R8 cop status (tx ready all)", v, 32'hAAAA);
        bus_rd(1, 9'h144, v); check("R1 count ch1", v, 0);
        check("R1 irqs low", {30'b0, app_irq, cop_irq}, 0);
    endtask

    task automatic t_dir();
        // ch0 app->cop, ch1 cop->app, ch2/3 cop->cop
        bus_wr(0, 9'h000, 32'h0000_0110);
        bus_rd(1, 9'h000, v); check("R2 word0 shared view", v, 32'h110);
        bus_wr(1, 9'h004, 32'hEEEE_EEEE);
        bus_rd(0, 9'h004, v); check("R2 unused bits read 0", v, 0);
        bus_wr(1, 9'h004, 32'h1111_1111);   // ch4..7 app->app
        bus_rd(0, 9'h004, v); check("R2 word1", v, 32'h1111_1111);
    endtask

    task automatic t_push_pop();
        bus_wr(0, 9'h180, 32'hA0);
        bus_wr(0, 9'h180, 32'hA1);
        bus_wr(0, 9'h180, 32'hA2);
        bus_rd(1, 9'h140, v); check("R3 count 3", v, 3);
        bus_rd(1, 9'h100, v); check("R3 not full", v, 0);
        bus_rd(1, 9'h180, v); check("R5 pop first", v, 32'hA0);
        bus_rd(1, 9'h180, v); check("R5 pop second", v, 32'hA1);
        bus_rd(1, 9'h140, v); check("R5 count 1", v, 1);
        bus_rd(0, 9'h180, v); check("R5 non-receiver read 0", v, 0);
        bus_rd(1, 9'h140, v); check("R5 non-receiver no pop", v, 1);
        bus_rd(1, 9'h070, v); check("R6 cop rx bit0", v & 1, 1);
        bus_rd(0, 9'h070, v); check("R6 app rx bit0 clear", v & 1, 0);
    endtask

    task automatic t_clear();
        bus_wr(1, 9'h070, 32'h1);
        bus_rd(1, 9'h070, v); check("R7 clear blocked", v & 1, 1);
        bus_rd(0, 9'h050, v); check("R10 peer status pending", v & 1, 1);
        bus_rd(1, 9'h180, v); check("R5 pop third", v, 32'hA2);
        bus_rd(1, 9'h070, v); check("R7 sticky after drain", v & 1, 1);
        bus_wr(1, 9'h070, 32'h1);
        bus_rd(1, 9'h070, v); check("R7 clear on empty", v & 1, 0);
        bus_rd(0, 9'h050, v); check("R10 peer acked", v & 1, 0);
        bus_wr(1, 9'h070, 32'hFFFF);
        bus_rd(1, 9'h070, v); check("R8 tx bits unwritable", v & 32'hAAAA, 32'hA8);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 5; i++) bus_wr(0, 9'h180, 32'hB0 + i);
        bus_rd(1, 9'h140, v); check("R4 count capped", v, 4);
        bus_rd(1, 9'h100, v); check("R3 full flag", v, 1);
        bus_rd(0, 9'h070, v); check("R8 tx bit low when full", v & 2, 0);
        for (int i = 0; i < 4; i++) begin
            bus_rd(1, 9'h180, v); check("R4 order, fifth dropped", v, 32'hB0 + i);
        end
        bus_rd(1, 9'h180, v); check("R5 empty pop 0", v, 0);
        bus_rd(1, 9'h140, v); check("R5 empty count", v, 0);
        bus_rd(0, 9'h070, v); check("R8 tx bit back", v & 2, 2);
        bus_wr(1, 9'h070, 32'h1);
    endtask

    task automatic t_wrong_side();
        bus_wr(1, 9'h180, 32'hDEAD);
        bus_rd(1, 9'h140, v); check("R4 wrong-side push ignored", v, 0);
        bus_rd(1, 9'h070, v); check("R4 no rx status", v & 1, 0);
        bus_wr(0, 9'h184, 32'hBEEF);
        bus_rd(0, 9'h144, v); check("R4 app push ch1 ignored", v, 0);
    endtask

    task automatic t_irq();
        bus_wr(0, 9'h060, 32'h4);
        @(negedge clk); check("R9 irq idle", {31'b0, app_irq}, 0);
        bus_wr(1, 9'h184, 32'h55);
        @(negedge clk); check("R9 irq on rx", {31'b0, app_irq}, 1);
        bus_rd(1, 9'h040, v); check("R10 peer enable", v, 4);
        bus_rd(0, 9'h184, v); check("R5 pop ch1", v, 32'h55);
        bus_wr(0, 9'h070, 32'h4);
        @(negedge clk); check("R9 irq cleared", {31'b0, app_irq}, 0);
        bus_wr(0, 9'h060, 32'h2);
        @(negedge clk); check("R9 irq on tx ready", {31'b0, app_irq}, 1);
        bus_wr(0, 9'h060, 32'h0);
        @(negedge clk); check("R9 irq masked", {30'b0, app_irq, cop_irq}, 0);
    endtask

    task automatic t_collision();
        @(negedge clk);
        app_sel = 1; app_wr = 1; app_addr = 9'h000; app_wdata = 32'h1;
        cop_sel = 1; cop_wr = 1; cop_addr = 9'h000; cop_wdata = 32'h10;
        @(posedge clk); #1;
        app_sel = 0; app_wr = 0; cop_sel = 0; cop_wr = 0;
        bus_rd(0, 9'h000, v); check("R2 cop wins collision", v, 32'h10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_dir();
        t_push_pop();
        t_clear();
        t_overflow();
        t_wrong_side();
        t_irq();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule